// File: doc/BRIEF.md
# Self-Starting Five-Step Sequence Counter

This block is a 3-bit synchronous counter that walks a fixed, non-binary loop of five codes and repeats it forever. The count value is the state itself. Each state bit is one flip-flop, and plain combinational equations compute the next state. Nothing else sits between the equations and the flip-flops.

Three of the eight codes are not part of the loop. The equations that drive the loop also decide what happens to those three codes. The equations were chosen so that every stray code falls back into the loop within two clocks. Because of this, the counter recovers from any power-up value even if reset is never asserted. A synchronous active-high reset is also provided. It loads a parameterised code, which is 000 by default. Setting the parameter to an unused code gives a direct way to start the counter off the loop.

Top module: `seqloop_top`

## Requirements
- R1: `count_o` is the 3-bit state with bit 2 as the most significant bit (C), bit 1 as B and bit 0 as A; it changes only on a rising clock edge.
- R2: While `rst` is high at a rising edge, the state becomes `RESET_CODE` (default 3'b000) at that edge, and it holds that value for as long as `rst` stays high.
- R3: From 3'b000 the next state is 3'b010.
- R4: From 3'b010 the next state is 3'b011.
- R5: From 3'b011 the next state is 3'b101.
- R6: From 3'b101 the next state is 3'b110.
- R7: From 3'b110 the next state is 3'b000, so the loop has a period of exactly five clocks.
- R8: The unused code 3'b001 moves to 3'b110.
- R9: The unused code 3'b100 moves to 3'b010.
- R10: The unused code 3'b111 moves to 3'b100.
- R11: From any starting code, the counter spends at most two consecutive clocks outside the loop {000, 010, 011, 101, 110}. Once it is inside the loop, it never leaves it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset to `RESET_CODE` |
| count_o | output | 3 | Current state, which is also the count value |

## Verification
The assertions check four things on every clock:
- each loop step and each stray-code step goes to its required successor;
- once the state is inside the loop, it stays inside;
- a counter of consecutive out-of-loop clocks never goes above two;
- reset lands on the configured code.

Some behaviour can only be shown by the bench scenarios. One instance is built per reset code, and from that code each instance walks its own trajectory. Together these trajectories cover the full successor map, the exact two-clock recovery from 3'b111, and the five-clock period.

// File: rtl/seqloop_pkg.sv
package seqloop_pkg;

    localparam int CNT_W = 3;

    typedef logic [CNT_W-1:0] code_t;

    typedef struct packed {
        logic c;
        logic b;
        logic a;
    } seq_state_t;

    localparam code_t LOOP_S0 = 3'b000;
    localparam code_t LOOP_S1 = 3'b010;
    localparam code_t LOOP_S2 = 3'b011;
    localparam code_t LOOP_S3 = 3'b101;
    localparam code_t LOOP_S4 = 3'b110;

    function automatic logic on_loop(input code_t v);
        return (v == LOOP_S0) || (v == LOOP_S1) || (v == LOOP_S2) ||
               (v == LOOP_S3) || (v == LOOP_S4);
    endfunction

endpackage

// File: rtl/seqloop_next.sv
module seqloop_next
    import seqloop_pkg::*;
(
    input  seq_state_t cur_i,
    output seq_state_t nxt_o
);

    // Minimised equations; stray codes are steered by the same terms.
    always_comb begin
        nxt_o.c = cur_i.a;
        nxt_o.b = ~cur_i.b | (~cur_i.a & ~cur_i.c);
        nxt_o.a = cur_i.b & ~cur_i.c;
    end

endmodule

// File: rtl/seqloop_reg.sv
module seqloop_reg
    import seqloop_pkg::*;
#(
    parameter code_t RESET_CODE = 3'b000
) (
    input  logic       clk,
    input  logic       rst,
    input  seq_state_t d_i,
    output seq_state_t q_o
);

    code_t d_vec;
    code_t q_vec;

    assign d_vec = code_t'(d_i);
    assign q_o   = seq_state_t'(q_vec);

    // One flip-flop per state bit.
    for (genvar bit_g = 0; bit_g < CNT_W; bit_g++) begin : g_ff
        always_ff @(posedge clk) begin
            if (rst) q_vec[bit_g] <= RESET_CODE[bit_g];
            else     q_vec[bit_g] <= d_vec[bit_g];
        end
    end

endmodule

// File: rtl/seqloop_top.sv
module seqloop_top
    import seqloop_pkg::*;
#(
    parameter code_t RESET_CODE = 3'b000
) (
    input  logic       clk,
    input  logic       rst,
    output logic [2:0] count_o
);

    seq_state_t cur_s;
    seq_state_t nxt_s;

    seqloop_next u_next (
        .cur_i (cur_s),
        .nxt_o (nxt_s)
    );

    seqloop_reg #(.RESET_CODE(RESET_CODE)) u_reg (
        .clk (clk),
        .rst (rst),
        .d_i (nxt_s),
        .q_o (cur_s)
    );

    assign count_o = code_t'(cur_s);

    // Consecutive out-of-loop clock counter used by the recovery check.
    logic [1:0] off_cnt_q;
    always_ff @(posedge clk) begin
        if (rst)                    off_cnt_q <= 2'd0;
        else if (on_loop(count_o))  off_cnt_q <= 2'd0;
        else if (off_cnt_q != 2'd3) off_cnt_q <= off_cnt_q + 2'd1;
    end

    AST_RESET_CODE: assert property (@(posedge clk) rst |=> count_o == RESET_CODE); // R2
    AST_STEP_S0: assert property (@(posedge clk) disable iff (rst) count_o == 3'b000 |=> count_o == 3'b010); // R3
    AST_STEP_S1: assert property (@(posedge clk) disable iff (rst) count_o == 3'b010 |=> count_o == 3'b011); // R4
    AST_STEP_S2: assert property (@(posedge clk) disable iff (rst) count_o == 3'b011 |=> count_o == 3'b101); // R5
    AST_STEP_S3: assert property (@(posedge clk) disable iff (rst) count_o == 3'b101 |=> count_o == 3'b110); // R6
    AST_STEP_S4: assert property (@(posedge clk) disable iff (rst) count_o == 3'b110 |=> count_o == 3'b000); // R7
    AST_STRAY_001: assert property (@(posedge clk) disable iff (rst) count_o == 3'b001 |=> count_o == 3'b110); // R8
    AST_STRAY_100: assert property (@(posedge clk) disable iff (rst) count_o == 3'b100 |=> count_o == 3'b010); // R9
    AST_STRAY_111: assert property (@(posedge clk) disable iff (rst) count_o == 3'b111 |=> count_o == 3'b100); // R10
    AST_LOOP_CLOSED: assert property (@(posedge clk) disable iff (rst) on_loop(count_o) |=> on_loop(count_o)); // R11
    AST_RECOVERY_BOUND: assert property (@(posedge clk) disable iff (rst) off_cnt_q <= 2'd2); // R11

endmodule

// File: tb/seqloop_top_tb_top.sv
module seqloop_top_tb_top;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;   // 125 MHz

    logic [2:0] q_all [8];

    seqloop_top #(.RESET_CODE(3'b000)) dut_i (
        .clk (clk), .rst (rst), .count_o (q_all[0])
    );

    for (genvar g = 1; g < 8; g++) begin : g_inst
        seqloop_top #(.RESET_CODE(3'(g))) u_cnt (
            .clk (clk), .rst (rst), .count_o (q_all[g])
        );
    end

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // Successor map taken from the requirements.
    function automatic logic [2:0] succ(input logic [2:0] v);
        case (v)
            3'b000: return 3'b010;
            3'b010: return 3'b011;
            3'b011: return 3'b101;
            3'b101: return 3'b110;
            3'b110: return 3'b000;
            3'b001: return 3'b110;
            3'b100: return 3'b010;
            default: return 3'b100;
        endcase
    endfunction

    function automatic string tag_of(input logic [2:0] v);
        case (v)
            3'b000: return "R3";
            3'b010: return "R4";
            3'b011: return "R5";
            3'b101: return "R6";
            3'b110: return "R7";
            3'b001: return "R8";
            3'b100: return "R9";
            default: return "R10";
        endcase
    endfunction

    function automatic bit in_loop(input logic [2:0] v);
        return v == 3'b000 || v == 3'b010 || v == 3'b011 || v == 3'b101 || v == 3'b110;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        logic [2:0] model [8];
        int off_run [8];
        bit was_in [8];
        @(negedge clk);
        rst = 1'b1;
        tick();
        tick();
        // R2: every instance sits at its own reset code, held over two edges
        for (int k = 0; k < 8; k++) begin
            check("R2", int'(q_all[k]), k);
            model[k]   = 3'(k);
            off_run[k] = 0;
            was_in[k]  = in_loop(3'(k));
        end
        rst = 1'b0;
        for (int cyc = 0; cyc < 15; cyc++) begin
            tick();
            for (int k = 0; k < 8; k++) begin
                // R1, R3..R10: each observed step follows the successor map
                check(tag_of(model[k]), int'(q_all[k]), int'(succ(model[k])));
                model[k] = succ(model[k]);
                off_run[k] = in_loop(q_all[k]) ? 0 : off_run[k] + 1;
                // R11: never more than two clocks off the loop
                check("R11", (off_run[k] <= 2) ? 1 : 0, 1);
                // R11: once on the loop it stays there
                if (was_in[k]) check("R11", in_loop(q_all[k]) ? 1 : 0, 1);
                was_in[k] = was_in[k] | in_loop(q_all[k]);
            end
        end
        // R7: the period is five, so dut_i returns to 000 after five more edges
        for (int cyc = 0; cyc < 5; cyc++) tick();
        check("R7", int'(q_all[0]), int'(model[0]));
        // R10 then R9: from 111 the loop is reached in exactly two clocks
        @(negedge clk); rst = 1'b1;
        tick();
        rst = 1'b0;
        check("R2", int'(q_all[7]), 7);
        tick();
        check("R10", int'(q_all[7]), 3'b100);
        tick();
        check("R9", int'(q_all[7]), 3'b010);
        check("R11", in_loop(q_all[7]) ? 1 : 0, 1);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 5000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule